// File: doc/BRIEF.md
# Message-signalled interrupt capability with message generator

This block sits on the device side of a configuration space. It holds one message-signalled interrupt capability structure: the header, control, target address, data, and the per-vector mask and pending registers. Software reaches it through a 32-bit configuration port. The port takes one dword index, one write strobe, and returns the read data in the same cycle. Device logic raises per-vector interrupt requests. The block turns each accepted request into a memory-write request, carrying a 64-bit address and 16 bits of data, on a valid/ready output.

Three settings decide whether a request goes out:

- the enable bit;
- the number of vectors software has enabled;
- the per-vector mask.

A masked request is held as a pending bit. It is sent as soon as software clears the mask. When several vectors wait at once, the lowest vector number goes first. One message is handed over per handshake.

Top module: `msi_cap_gen`

## Requirements
- R1: Dword 0 reads ID 0x05 in bits 7-0, NEXT_PTR in bits 15-8 and the control word in bits 31-16. In the control word, bit 0 is enable, bits 3-1 are the vector capability MMC_LOG2, bits 6-4 are the enabled-vector exponent, bit 7 is 1 when 64-bit addressing is present, bit 8 is 1 when masking is present, and bits 15-9 read 0. After reset, enable and the exponent are 0.
- R2: A write to dword 0 changes only enable (write bit 16) and the exponent (write bits 22-20). An exponent above MMC_LOG2 is stored as MMC_LOG2.
- R3: The address low register is dword 1, and its bits 1-0 read 0. With 64-bit addressing, address high is dword 2 and data is dword 3. Without it, data is dword 2. Data reads back its low 16 bits with bits 31-16 as 0. Dword indices not mapped read 0 and ignore writes.
- R4: Masking is present only when both PV_MASK and ADDR64 are set. When present, dword 4 is the mask and dword 5 is the pending register, with bit n standing for vector n. Mask bits at or above 2^MMC_LOG2 read 0. Writes to dword 5 have no effect.
- R5: While enable is 0, requests are dropped and no message is sent.
- R6: With enable set, an unmasked request for vector v below 2^exponent raises msg_valid at the second rising edge after the request is sampled. The address and data then stay stable until msg_ready is seen high.
- R7: The message data is the programmed data with its low exponent bits replaced by the vector number.
- R8: Requests for vectors at or above 2^exponent are ignored.
- R9: A request on a masked vector sets its pending bit and sends no message.
- R10: While enable is 1 and a vector is unmasked, a pending bit on that vector produces its message and the pending bit clears. The message is valid at the second rising edge after the write that clears the mask.
- R11: The message address is {address high, address low with bits 1-0 zero}. Without 64-bit addressing the upper 32 bits are 0.
- R12: Waiting vectors are sent lowest number first, one per handshake. The next message is loaded at the same edge as the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 4 | Dword index within the capability |
| cfg_wr | input | 1 | Write strobe, one dword per cycle |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, same cycle |
| irq_req | input | 2^MMC_LOG2 | Per-vector request, sampled each rising edge |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_addr | output | 64 | Memory-write target address |
| msg_data | output | 16 | Memory-write data |

## Verification
A request sampled at one rising edge shows up on msg_valid after the following edge. The directed checks therefore sample one full clock after the request pulse has been removed. An unmask takes effect one edge after the clearing write. The waiting message is therefore checked one cycle after the write task returns. After a handshake, the next waiting vector is already valid in the cycle that follows. Configuration reads are combinational, so they are sampled shortly after the index is driven, in the same cycle. On every clock, a behavioural model updated at the rising edge is compared with the outputs 2 ns after that edge, clear of the input changes made at falling edges.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam logic [7:0] MSI_CAP_ID = 8'h05;

    localparam logic [3:0] DW_HEAD    = 4'd0;
    localparam logic [3:0] DW_ADDR_LO = 4'd1;
    localparam logic [3:0] DW_SLOT2   = 4'd2;
    localparam logic [3:0] DW_SLOT3   = 4'd3;
    localparam logic [3:0] DW_MASK    = 4'd4;
    localparam logic [3:0] DW_PEND    = 4'd5;

    typedef struct packed {
        logic       enable;
        logic [2:0] mme;
    } msi_ctrl_t;

    typedef struct packed {
        logic [63:0] addr;
        logic [15:0] data;
    } msi_msg_t;

    function automatic logic [2:0] clamp_mme(logic [2:0] req, logic [2:0] cap);
        return (req > cap) ? cap : req;
    endfunction

    function automatic logic [15:0] fold_vector(logic [15:0] base, logic [2:0] mme,
                                                logic [4:0] vec);
        logic [15:0] low;
        low = (16'd1 << mme) - 16'd1;
        return (base & ~low) | ({11'd0, vec} & low);
    endfunction

    function automatic logic [15:0] ctrl_word(msi_ctrl_t c, logic [2:0] mmc,
                                              logic has64, logic hasmask);
        return {7'd0, hasmask, has64, c.mme, mmc, c.enable};
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_pkg::*;
#(
    parameter int         MMC_LOG2 = 3,
    parameter int         NVEC     = 8,
    parameter bit         HAS64    = 1'b1,
    parameter bit         HASMASK  = 1'b1,
    parameter logic [7:0] NEXT_PTR = 8'h40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      cfg_addr,
    input  logic            cfg_wr,
    input  logic [31:0]     cfg_wdata,
    output logic [31:0]     cfg_rdata,
    input  logic [NVEC-1:0] pend,
    output msi_ctrl_t       ctrl,
    output logic [31:0]     addr_lo,
    output logic [31:0]     addr_hi,
    output logic [15:0]     data,
    output logic [NVEC-1:0] mask
);

    localparam logic [2:0] MMC3    = 3'(MMC_LOG2);
    localparam logic [3:0] DATA_DW = HAS64 ? DW_SLOT3 : DW_SLOT2;

    msi_ctrl_t       ctrl_q;
    logic [29:0]     alo_q;
    logic [15:0]     data_q;
    logic [31:0]     ahi_q;
    logic [NVEC-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            alo_q  <= '0;
            data_q <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr == DW_HEAD) begin
                ctrl_q.enable <= cfg_wdata[16];
                ctrl_q.mme    <= clamp_mme(cfg_wdata[22:20], MMC3);
            end
            if (cfg_addr == DW_ADDR_LO) alo_q  <= cfg_wdata[31:2];
            if (cfg_addr == DATA_DW)    data_q <= cfg_wdata[15:0];
        end
    end

    generate
        if (HAS64) begin : g_hi
            always_ff @(posedge clk) begin
                if (rst)                               ahi_q <= '0;
                else if (cfg_wr && cfg_addr == DW_SLOT2) ahi_q <= cfg_wdata;
            end
        end else begin : g_no_hi
            assign ahi_q = '0;
        end

        if (HASMASK) begin : g_mask
            always_ff @(posedge clk) begin
                if (rst)                                mask_q <= '0;
                else if (cfg_wr && cfg_addr == DW_MASK) mask_q <= cfg_wdata[NVEC-1:0];
            end
        end else begin : g_no_mask
            assign mask_q = '0;
        end
    endgenerate

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            DW_HEAD:    cfg_rdata = {ctrl_word(ctrl_q, MMC3, HAS64, HASMASK), NEXT_PTR, MSI_CAP_ID};
            DW_ADDR_LO: cfg_rdata = {alo_q, 2'b00};
            DW_SLOT2:   cfg_rdata = HAS64 ? ahi_q : {16'd0, data_q};
            DW_SLOT3:   cfg_rdata = HAS64 ? {16'd0, data_q} : 32'd0;
            DW_MASK:    cfg_rdata = HASMASK ? 32'(mask_q) : 32'd0;
            DW_PEND:    cfg_rdata = HASMASK ? 32'(pend) : 32'd0;
            default:    cfg_rdata = '0;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign addr_lo = {alo_q, 2'b00};
    assign addr_hi = ahi_q;
    assign data    = data_q;
    assign mask    = mask_q;

    AST_MME_CLAMP: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.mme <= MMC3); // R2

endmodule

// File: rtl/msi_vec_tracker.sv
module msi_vec_tracker
    import msi_pkg::*;
#(
    parameter int NVEC    = 8,
    parameter bit HASMASK = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NVEC-1:0] irq_req,
    input  msi_ctrl_t       ctrl,
    input  logic [NVEC-1:0] mask,
    input  logic            slot_free,
    output logic [NVEC-1:0] pend,
    output logic            fire,
    output logic [4:0]      sel_vec
);

    logic [NVEC-1:0] want_q, pend_q, in_range, accept, cand, clr;

    always_comb begin
        for (int i = 0; i < NVEC; i++)
            in_range[i] = (32'(i) < (32'd1 << ctrl.mme));
    end

    assign accept = irq_req & in_range & {NVEC{ctrl.enable}};
    assign cand   = want_q | (pend_q & ~mask);

    always_comb begin
        sel_vec = '0;
        for (int i = NVEC - 1; i >= 0; i--)
            if (cand[i]) sel_vec = 5'(i);
    end

    assign fire = ctrl.enable && slot_free && (|cand);
    assign clr  = fire ? (NVEC'(1) << sel_vec) : '0;

    always_ff @(posedge clk) begin
        if (rst) want_q <= '0;
        else     want_q <= (want_q & ~clr) | (accept & ~mask);
    end

    generate
        if (HASMASK) begin : g_pend
            always_ff @(posedge clk) begin
                if (rst) pend_q <= '0;
                else     pend_q <= (pend_q & ~clr) | (accept & mask);
            end
        end else begin : g_no_pend
            assign pend_q = '0;
        end
    endgenerate

    assign pend = pend_q;

    AST_PEND_ONLY_MASKED: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~$past(pend_q) & ~$past(mask)) == '0); // R9

    AST_NO_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        ((want_q | pend_q) & ~$past(want_q | pend_q) & ~$past(in_range)) == '0); // R8

endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
    import msi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [4:0]  vec,
    input  logic [2:0]  mme,
    input  logic [31:0] addr_lo,
    input  logic [31:0] addr_hi,
    input  logic [15:0] data,
    input  logic        msg_ready,
    output logic        slot_free,
    output logic        msg_valid,
    output msi_msg_t    msg
);

    msi_msg_t msg_q;
    logic     valid_q;

    assign slot_free = !valid_q || msg_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
        end else if (load) begin
            valid_q    <= 1'b1;
            msg_q.addr <= {addr_hi, addr_lo};
            msg_q.data <= fold_vector(data, mme, vec);
        end else if (msg_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign msg_valid = valid_q;
    assign msg       = msg_q;

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        valid_q && !msg_ready |=> valid_q && $stable(msg_q)); // R6

    AST_ADDR_DWORD: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> msg_q.addr[1:0] == 2'b00); // R11

endmodule

// File: rtl/msi_cap_gen.sv
module msi_cap_gen
    import msi_pkg::*;
#(
    parameter int         MMC_LOG2 = 3,
    parameter bit         ADDR64   = 1'b1,
    parameter bit         PV_MASK  = 1'b1,
    parameter logic [7:0] NEXT_PTR = 8'h40
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [3:0]               cfg_addr,
    input  logic                     cfg_wr,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    input  logic [(1<<MMC_LOG2)-1:0] irq_req,
    output logic                     msg_valid,
    input  logic                     msg_ready,
    output logic [63:0]              msg_addr,
    output logic [15:0]              msg_data
);

    localparam int NVEC    = 1 << MMC_LOG2;
    localparam bit HASMASK = PV_MASK && ADDR64;

    msi_ctrl_t       ctrl;
    logic [31:0]     addr_lo, addr_hi;
    logic [15:0]     data;
    logic [NVEC-1:0] mask, pend;
    logic            slot_free, fire;
    logic [4:0]      sel_vec;
    msi_msg_t        msg;

    msi_cfg_regs #(
        .MMC_LOG2(MMC_LOG2), .NVEC(NVEC), .HAS64(ADDR64),
        .HASMASK(HASMASK), .NEXT_PTR(NEXT_PTR)
    ) u_regs (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pend(pend),
        .ctrl(ctrl), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .data(data), .mask(mask)
    );

    msi_vec_tracker #(.NVEC(NVEC), .HASMASK(HASMASK)) u_track (
        .clk(clk), .rst(rst), .irq_req(irq_req), .ctrl(ctrl), .mask(mask),
        .slot_free(slot_free), .pend(pend), .fire(fire), .sel_vec(sel_vec)
    );

    msi_msg_out u_out (
        .clk(clk), .rst(rst), .load(fire), .vec(sel_vec), .mme(ctrl.mme),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .data(data),
        .msg_ready(msg_ready), .slot_free(slot_free),
        .msg_valid(msg_valid), .msg(msg)
    );

    assign msg_addr = msg.addr;
    assign msg_data = msg.data;

    AST_SEND_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> $past(ctrl.enable)); // R5

endmodule

// File: tb/msi_cap_gen_bench.sv
module msi_cap_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  irq_req = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [63:0] msg_addr;
    logic [15:0] msg_data;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    msi_cap_gen u_msi_cap_gen (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit        m_en;
    int        m_mme;
    bit [31:0] m_alo, m_ahi;
    bit [15:0] m_dat;
    bit [7:0]  m_mask, m_pend, m_want;
    bit        m_valid;
    bit [63:0] m_addr;
    bit [15:0] m_data;

    function automatic bit [15:0] exp_fold(bit [15:0] d, int mme, int v);
        int low;
        low = (1 << mme) - 1;
        return 16'((int'(d) & ~low) | (v & low));
    endfunction

    function automatic bit [31:0] exp_read(int idx);
        bit [15:0] c;
        c = {7'd0, 1'b1, 1'b1, 3'(m_mme), 3'd3, m_en};
        case (idx)
            0: return {c, 8'h40, 8'h05};
            1: return m_alo & 32'hFFFF_FFFC;
            2: return m_ahi;
            3: return {16'd0, m_dat};
            4: return {24'd0, m_mask};
            5: return {24'd0, m_pend};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_mme = 0; m_alo = 0; m_ahi = 0; m_dat = 0;
            m_mask = 0; m_pend = 0; m_want = 0; m_valid = 0; m_addr = 0; m_data = 0;
        end else begin
            bit       o_en, free;
            int       o_mme;
            bit [7:0] o_mask, cand;
            o_en = m_en; o_mme = m_mme; o_mask = m_mask;
            free = !m_valid || msg_ready;
            if (m_valid && msg_ready) m_valid = 0;
            cand = m_want | (m_pend & ~o_mask);
            if (o_en && free && cand != 0) begin
                int v;
                v = 0;
                while (!cand[v]) v++;
                m_want[v] = 0;
                m_pend[v] = 0;
                m_valid = 1;
                m_addr = {m_ahi, m_alo & 32'hFFFF_FFFC};
                m_data = exp_fold(m_dat, o_mme, v);
            end
            for (int v = 0; v < 8; v++) begin
                if (irq_req[v] && o_en && v < (1 << o_mme)) begin
                    if (o_mask[v]) m_pend[v] = 1;
                    else           m_want[v] = 1;
                end
            end
            if (cfg_wr) begin
                case (cfg_addr)
                    4'd0: begin
                        m_en = cfg_wdata[16];
                        m_mme = (cfg_wdata[22:20] > 3) ? 3 : int'(cfg_wdata[22:20]);
                    end
                    4'd1: m_alo = cfg_wdata;
                    4'd2: m_ahi = cfg_wdata;
                    4'd3: m_dat = cfg_wdata[15:0];
                    4'd4: m_mask = cfg_wdata[7:0];
                    default: ;
                endcase
            end
        end
        #2;
        if (!rst) begin
            check("R6 model msg_valid", 64'(msg_valid), 64'(m_valid));
            if (m_valid) begin
                check("R7 model msg_data", 64'(msg_data), 64'(m_data));
                check("R11 model msg_addr", msg_addr, m_addr);
            end
            check("R3 model cfg_rdata", 64'(cfg_rdata), 64'(exp_read(int'(cfg_addr))));
        end
    end

    task automatic cfg_write(logic [3:0] idx, logic [31:0] d);
        @(negedge clk);
        cfg_addr = idx; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(logic [3:0] idx, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = idx;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse(logic [7:0] m);
        @(negedge clk);
        irq_req = m;
        @(negedge clk);
        irq_req = '0;
        @(negedge clk);
        #1;
    endtask

    task automatic handshake();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        #1;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 check("R1 reset msg_valid", 64'(msg_valid), 64'd0);
        cfg_read(4'd0, rd);
        check("R1 reset header", 64'(rd), 64'h0186_4005);

        cfg_write(4'd1, 32'hFEE0_1003);
        cfg_read(4'd1, rd);
        check("R3 addr low alignment", 64'(rd), 64'hFEE0_1000);
        cfg_write(4'd3, 32'hABCD_1230);
        cfg_read(4'd3, rd);
        check("R3 data upper zero", 64'(rd), 64'h0000_1230);
        cfg_write(4'd7, 32'hFFFF_FFFF);
        cfg_read(4'd7, rd);
        check("R3 unmapped reads zero", 64'(rd), 64'd0);

        pulse(8'h01);
        check("R5 disabled no message", 64'(msg_valid), 64'd0);

        cfg_write(4'd0, 32'h0071_0000);
        cfg_read(4'd0, rd);
        check("R2 mme clamp and enable", 64'(rd), 64'h01B7_4005);

        pulse(8'h20);
        check("R6 message valid", 64'(msg_valid), 64'd1);
        check("R7 vector folded", 64'(msg_data), 64'h1235);
        check("R11 address 32-bit", msg_addr, 64'h0000_0000_FEE0_1000);
        @(negedge clk); #1;
        check("R6 held while not ready", 64'(msg_valid), 64'd1);
        check("R6 data stable", 64'(msg_data), 64'h1235);
        handshake();
        check("R6 cleared after handshake", 64'(msg_valid), 64'd0);

        cfg_write(4'd0, 32'h0011_0000);
        pulse(8'h08);
        check("R8 out of range ignored", 64'(msg_valid), 64'd0);
        pulse(8'h02);
        check("R7 fold with one bit", 64'(msg_data), 64'h1231);
        handshake();

        cfg_write(4'd2, 32'h0000_0001);
        pulse(8'h01);
        check("R11 address 64-bit", msg_addr, 64'h0000_0001_FEE0_1000);
        check("R7 vector zero", 64'(msg_data), 64'h1230);
        handshake();

        cfg_write(4'd4, 32'hFFFF_FFFF);
        cfg_read(4'd4, rd);
        check("R4 mask width", 64'(rd), 64'h0000_00FF);
        cfg_write(4'd4, 32'h0000_0002);
        pulse(8'h02);
        check("R9 masked no message", 64'(msg_valid), 64'd0);
        cfg_read(4'd5, rd);
        check("R9 pending set", 64'(rd), 64'h2);
        cfg_write(4'd5, 32'h0);
        cfg_read(4'd5, rd);
        check("R4 pending read-only", 64'(rd), 64'h2);
        cfg_write(4'd4, 32'h0);
        @(negedge clk); #1;
        check("R10 unmask sends", 64'(msg_valid), 64'd1);
        check("R10 unmask data", 64'(msg_data), 64'h1231);
        handshake();
        cfg_read(4'd5, rd);
        check("R10 pending cleared", 64'(rd), 64'h0);

        cfg_write(4'd0, 32'h0031_0000);
        pulse(8'h44);
        check("R12 lowest first", 64'(msg_data), 64'h1232);
        handshake();
        check("R12 next valid", 64'(msg_valid), 64'd1);
        check("R12 next vector", 64'(msg_data), 64'h1236);
        handshake();
        check("R12 queue drained", 64'(msg_valid), 64'd0);

        cfg_write(4'd0, 32'h0030_0000);
        pulse(8'h01);
        check("R5 disabled again", 64'(msg_valid), 64'd0);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule